// File: doc/BRIEF.md
# Port Interrupt and Low-Power Wake Unit

This block turns a set of external port inputs into latched interrupt requests for a low-power controller, and raises a restart request while the clocks are stopped. In run mode every pin is resampled through a two-stage clocked synchronizer. A per-port polarity bit then chooses whether a rising or a falling transition counts as an event. An event sets a sticky factor flag, which software clears by writing a one. The interrupt seen by the core is the flag masked by a per-port enable.

In the two stop-clock states (HALT2 and SLEEP) the synchronizer cannot be relied on. A separate combinational path therefore looks at the raw pin. It asserts the wake request whenever an enabled pin sits at the level that its edge polarity implies: high for rising, low for falling. A pin that is already at that level when the low-power state is entered wakes the controller at once. System software must treat port wake-up as level-sensitive.

All clocked port logic runs only while the prescaler enable is high. The factor flags have no reset value and must be cleared by software before the enables are set.

Top module: `pint_top`

## Requirements
- R1: A pin transition reaches its factor flag through two synchronizer stages and one delay stage. The flag is still clear after two enabled clock edges that follow the pin change, and is set after the third.
- R2: Each port has a polarity bit. When it is 1, only a 0-to-1 transition of the synchronized pin sets the flag. When it is 0, only a 1-to-0 transition does. A transition of the opposite direction leaves the flag unchanged.
- R3: A set factor flag stays set until a clock edge at which the matching bit of flag_clr_i is 1 (write-one-to-clear) while the prescaler runs.
- R4: If a new event and a clear of the same bit fall on the same clock edge, the flag ends up set.
- R5: While presc_en_i is 0, the synchronizer and the factor flags hold their values. Pin transitions and clear strobes in that interval leave the flags unchanged.
- R6: irq_o is the bitwise AND of the factor flags and irq_en_i.
- R7: The lp_mode_i encoding is 00 run, 01 HALT2, 10 SLEEP. In HALT2 or SLEEP, wake_o is 1 exactly when some port has irq_en_i set and its pin at the active level (high for polarity 1, low for polarity 0). In run mode and for code 11, wake_o is 0.
- R8: wake_o follows the pin and mode combinationally, with no clock and with the prescaler stopped. An enabled pin that is already active when the low-power mode is selected raises wake_o in the same instant.
- R9: Reset clears the synchronizer but does not change the factor flags. A flag set before reset reads the same after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| presc_en_i | input | 1 | Prescaler running; gates all clocked port logic |
| lp_mode_i | input | 2 | 00 run, 01 HALT2, 10 SLEEP |
| pin_i | input | N | Raw port input levels |
| pol_rise_i | input | N | Per-port polarity: 1 rising, 0 falling |
| irq_en_i | input | N | Per-port interrupt and wake enable |
| flag_clr_i | input | N | Write-one-to-clear strobe for the factor flags |
| flag_o | output | N | Interrupt factor flags |
| irq_o | output | N | Enabled interrupt requests |
| wake_o | output | 1 | Restart request in HALT2 or SLEEP |

## Verification
On every cycle the assertions check three things: set flags are never lost without a clear strobe, no flag rises while the prescaler is stopped, and wake_o stays low in run mode or with every enable off. The three-edge latency, the choice of polarity, set-over-clear in a single cycle, the level-based immediate wake and flag retention across reset show only in the bench scenarios. There a behavioural model tracks every port on every clock.

// File: rtl/pint_pkg.sv
package pint_pkg;
  typedef enum logic [1:0] {
    LP_RUN   = 2'b00,
    LP_HALT2 = 2'b01,
    LP_SLEEP = 2'b10,
    LP_RSVD  = 2'b11
  } lp_mode_e;

  function automatic logic lp_stop_clk(input lp_mode_e m);
    return (m == LP_HALT2) || (m == LP_SLEEP);
  endfunction
endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] q_dly_o
);
  logic [N-1:0] s1_q, s2_q, dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      dly_q <= '0;
    end else if (en_i) begin
      s1_q  <= d_i;
      s2_q  <= s1_q;
      dly_q <= s2_q;
    end
  end

  assign q_o     = s2_q;
  assign q_dly_o = dly_q;
endmodule

// File: rtl/pint_edge.sv
module pint_edge #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] pol_rise_i,
  output logic [N-1:0] evt_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic rise, fall;
    assign rise     = cur_i[g] & ~prev_i[g];
    assign fall     = ~cur_i[g] & prev_i[g];
    assign evt_o[g] = pol_rise_i[g] ? rise : fall;
  end
endmodule

// File: rtl/pint_flag.sv
module pint_flag #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         en_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  // no reset: value after power-up is undefined, software clears it
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic flag_q;
    always_ff @(posedge clk_i) begin
      if (en_i) begin
        if (set_i[g])      flag_q <= 1'b1;  // new event beats clear
        else if (clr_i[g]) flag_q <= 1'b0;
      end
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/pint_wake.sv
module pint_wake #(
  parameter int unsigned N = 4
) (
  input  pint_pkg::lp_mode_e mode_i,
  input  logic [N-1:0]       pin_i,
  input  logic [N-1:0]       pol_rise_i,
  input  logic [N-1:0]       en_i,
  output logic               wake_o
);
  logic [N-1:0] lvl_act;
  logic         stop_clk;

  // edge setting becomes a level condition: raw pin, no synchronizer
  assign lvl_act  = ~(pin_i ^ pol_rise_i) & en_i;
  assign stop_clk = pint_pkg::lp_stop_clk(mode_i);
  assign wake_o   = stop_clk & (|lvl_act);
endmodule

// File: rtl/pint_top.sv
module pint_top #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         presc_en_i,
  input  logic [1:0]   lp_mode_i,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] pol_rise_i,
  input  logic [N-1:0] irq_en_i,
  input  logic [N-1:0] flag_clr_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] irq_o,
  output logic         wake_o
);
  import pint_pkg::*;

  logic [N-1:0] sync_cur, sync_prev, evt;
  lp_mode_e     mode;

  assign mode = lp_mode_e'(lp_mode_i);

  pint_sync #(.N(N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (presc_en_i),
    .d_i     (pin_i),
    .q_o     (sync_cur),
    .q_dly_o (sync_prev)
  );

  pint_edge #(.N(N)) u_edge (
    .cur_i      (sync_cur),
    .prev_i     (sync_prev),
    .pol_rise_i (pol_rise_i),
    .evt_o      (evt)
  );

  pint_flag #(.N(N)) u_flag (
    .clk_i  (clk_i),
    .en_i   (presc_en_i),
    .set_i  (evt),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  pint_wake #(.N(N)) u_wake (
    .mode_i     (mode),
    .pin_i      (pin_i),
    .pol_rise_i (pol_rise_i),
    .en_i       (irq_en_i),
    .wake_o     (wake_o)
  );

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/pint_chk.sv
module pint_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         presc_en_i,
  input logic [1:0]   lp_mode_i,
  input logic [N-1:0] irq_en_i,
  input logic [N-1:0] flag_clr_i,
  input logic [N-1:0] flag_o,
  input logic         wake_o
);
  logic [N-1:0] keep;
  assign keep = flag_o & ~(flag_clr_i & {N{presc_en_i}});

  a_r3_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_o & $past(keep)) == $past(keep)));

  a_r5_no_set_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !presc_en_i |=> ((flag_o & ~$past(flag_o)) == '0));

  a_r7_quiet_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode_i == 2'b00 || lp_mode_i == 2'b11) |-> !wake_o);

  a_r7_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !wake_o);
endmodule

bind pint_top pint_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .presc_en_i (presc_en_i),
  .lp_mode_i  (lp_mode_i),
  .irq_en_i   (irq_en_i),
  .flag_clr_i (flag_clr_i),
  .flag_o     (flag_o),
  .wake_o     (wake_o)
);

// File: tb/sim_pint_top.sv
module sim_pint_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         presc_en;
  logic [1:0]   lp_mode;
  logic [N-1:0] pin, pol, en, clr;
  logic [N-1:0] flag_o, irq_o;
  logic         wake_o;
  int           checks = 0, errors = 0;
  bit           done = 0;

  always #4 clk = ~clk;

  pint_top #(.N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .presc_en_i(presc_en), .lp_mode_i(lp_mode),
    .pin_i(pin), .pol_rise_i(pol), .irq_en_i(en), .flag_clr_i(clr),
    .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o));

  // behavioural reference: queue of the last three sampled pin vectors
  logic [N-1:0] hist_q[$];
  logic [N-1:0] m_flag = '0, m_known = '0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q = {};
      repeat (3) hist_q.push_front('0);
    end else if (presc_en) begin
      logic [N-1:0] ev;
      ev = (pol & hist_q[1] & ~hist_q[2]) | (~pol & ~hist_q[1] & hist_q[2]);
      m_flag  = (m_flag & ~clr) | ev;
      m_known = m_known | clr | ev;
      hist_q.push_front(pin);
      void'(hist_q.pop_back());
    end
  end

  function automatic logic exp_wake();
    logic lp = (lp_mode == 2'b01) || (lp_mode == 2'b10);
    return lp && (|(~(pin ^ pol) & en));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk((((flag_o ^ m_flag) & m_known) == '0), "R3 flag vs model", 32'(flag_o), 32'(m_flag));
      chk((((irq_o ^ (m_flag & en)) & m_known) == '0), "R6 irq vs model", 32'(irq_o), 32'(m_flag & en));
      chk(wake_o == exp_wake(), "R7 wake vs model", 32'(wake_o), 32'(exp_wake()));
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_ni = 0; presc_en = 1; lp_mode = 2'b00;
    pin = '0; pol = '1; en = '0; clr = '0;
    step(2);
    rst_ni = 1;
    step(1);
    chk(wake_o == 1'b0, "R7 reset wake", 32'(wake_o), 0);
    chk(irq_o == '0, "R6 reset irq", 32'(irq_o), 0);
    clr = '1; step(1); clr = '0;
    chk(flag_o == '0, "R3 cleared", 32'(flag_o), 0);

    // R1 latency, rising
    pin[0] = 1; step(2);
    chk(flag_o[0] == 1'b0, "R1 two edges", 32'(flag_o[0]), 0);
    step(1);
    chk(flag_o[0] == 1'b1, "R1 third edge", 32'(flag_o[0]), 1);
    // R3 hold across opposite transition
    pin[0] = 0; step(5);
    chk(flag_o[0] == 1'b1, "R3 held", 32'(flag_o[0]), 1);
    clr[0] = 1; step(1); clr[0] = 0;
    chk(flag_o[0] == 1'b0, "R3 w1c", 32'(flag_o[0]), 0);

    // R2 falling polarity on port 1
    pol[1] = 0; step(4);
    pin[1] = 1; step(5);
    chk(flag_o[1] == 1'b0, "R2 rise ignored for fall pol", 32'(flag_o[1]), 0);
    pin[1] = 0; step(3);
    chk(flag_o[1] == 1'b1, "R2 fall sets", 32'(flag_o[1]), 1);
    clr[1] = 1; step(1); clr[1] = 0;

    // R4 set beats clear; flag0 set first, cleared in same cycle as new edge
    pin[0] = 1; step(3); pin[0] = 0; step(4);
    chk(flag_o[0] == 1'b1, "R4 setup", 32'(flag_o[0]), 1);
    pin[0] = 1; step(2);
    clr[0] = 1; step(1); clr[0] = 0;
    chk(flag_o[0] == 1'b1, "R4 set wins", 32'(flag_o[0]), 1);
    pin[0] = 0; step(3);

    // R5 prescaler stopped
    presc_en = 0;
    pin[2] = 1; clr[0] = 1; step(6); clr[0] = 0;
    chk(flag_o[2] == 1'b0, "R5 no set when stopped", 32'(flag_o[2]), 0);
    chk(flag_o[0] == 1'b1, "R5 no clear when stopped", 32'(flag_o[0]), 1);
    presc_en = 1; step(2);
    chk(flag_o[2] == 1'b0, "R5 resumes two edges", 32'(flag_o[2]), 0);
    step(1);
    chk(flag_o[2] == 1'b1, "R5 resumes third edge", 32'(flag_o[2]), 1);

    // R6 masking
    en = 4'b0101; #1;
    chk(irq_o == (flag_o & 4'b0101), "R6 mask", 32'(irq_o), 32'(flag_o & 4'b0101));
    en = '0; clr = '1; step(1); clr = '0;

    // R7/R8 wake with clock stopped
    presc_en = 0; pol = '1; pin = 4'b1000; en = 4'b1000; #1;
    chk(wake_o == 1'b0, "R7 run no wake", 32'(wake_o), 0);
    lp_mode = 2'b10; #1;
    chk(wake_o == 1'b1, "R8 immediate sleep wake", 32'(wake_o), 1);
    pin[3] = 0; #1;
    chk(wake_o == 1'b0, "R7 inactive level", 32'(wake_o), 0);
    pol[3] = 0; #1;
    chk(wake_o == 1'b1, "R7 low level for fall pol", 32'(wake_o), 1);
    en[3] = 0; #1;
    chk(wake_o == 1'b0, "R7 disabled", 32'(wake_o), 0);
    en[3] = 1; lp_mode = 2'b01; #1;
    chk(wake_o == 1'b1, "R8 halt2 wake", 32'(wake_o), 1);
    lp_mode = 2'b11; #1;
    chk(wake_o == 1'b0, "R7 code 11 no wake", 32'(wake_o), 0);
    lp_mode = 2'b00; pol = '1; pin = '0; en = '0;
    presc_en = 1; step(4);

    // R9 flag survives reset
    pin[1] = 1; step(4);
    chk(flag_o[1] == 1'b1, "R9 setup", 32'(flag_o[1]), 1);
    rst_ni = 0; step(2); rst_ni = 1; step(1);
    chk(flag_o[1] == 1'b1, "R9 kept through reset", 32'(flag_o[1]), 1);
    step(4);
    finish_run();
  end
endmodule